// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's-complement operands over several clock cycles, retiring one Booth recoding step per iteration. A pulse on `start` while the block is idle captures the multiplicand and the multiplier. The block then runs one step for each multiplier bit and raises `done` for a single cycle when the full double-width product is ready on `product`.

The design has a controller and a datapath. The controller state machine sees only three things from the datapath: the low bit of the multiplier shift register, the one-bit extension register beside it, and whether the iteration counter has reached zero. From these it issues five strobes: parallel load, add, subtract, arithmetic right shift and counter decrement. The datapath keeps the multiplicand, an accumulator that carries one guard bit above the operand width, the multiplier/low-product shift register, the extension bit and a down counter. The guard bit keeps intermediate sums exact when the multiplicand is the most negative value.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `done` is low and `product` reads zero.
- R2: When `start` is high in the idle state, the clock edge captures both operands. Starting with the next cycle, `product` reads `{WIDTH zeros, multiplier}`, because the accumulator and the extension bit are cleared.
- R3: Each iteration looks at the pair formed by the register low bit (upper position) and the extension bit (lower position). Pair 10 subtracts the multiplicand from the accumulator. Pair 01 adds it. Pairs 00 and 11 leave the accumulator unchanged.
- R4: After the add or subtract, the block shifts the concatenation of accumulator, register and extension bit right by one place arithmetically. The accumulator sign is replicated, the accumulator LSB enters the register MSB, and the register LSB moves into the extension bit. With multiplier bit 0 set, `product` after the first iteration equals `{((-M)>>>1)[W-1:0], (-M)[0], multiplier[W-1:1]}`.
- R5: Exactly WIDTH iterations run. `done` goes high after the 2*WIDTH-th clock edge following the start edge, and it stays high for exactly one cycle.
- R6: When `done` is high, `product` equals the signed product of the operands, including operands of -2^(W-1), zero, +1 and -1.
- R7: A `start` pulse that arrives while an operation is in progress is ignored. Neither the result nor the completion time changes.
- R8: After `done`, `product` holds its value until the next accepted `start`.
- R9: At most one of load, add, subtract and shift is active in any cycle, and a decrement only comes together with a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed product {accumulator, low register} |

## Verification
The checker enforces the following on every cycle:
- the strobes are mutually exclusive;
- loads happen only on `start` and never during an operation;
- every shift moves the accumulator LSB into the low register;
- the iteration total is WIDTH when `done` rises, and `done` is a single-cycle pulse;
- the result stays frozen after completion.

The arithmetic itself, meaning the correct add/subtract selection and the final signed value, can only be shown by the bench scenarios. These include an exhaustive sweep of a 4-bit instance, a corner-value cross at 16 bits covering the most negative operand, random operand pairs, a probe of the first iteration, and a `start` injected mid-operation.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARITH = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } booth_state_e;

  typedef struct packed {
    logic load;
    logic add;
    logic sub;
    logic shift;
    logic dc;
  } booth_ctl_t;

endpackage

// File: rtl/booth_addsub.sv
module booth_addsub #(
  parameter int W = 17
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);

  logic [W-1:0] b_sel;

  always_comb begin
    b_sel = sub ? ~b : b;
    y     = a + b_sel + W'(sub);
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       q0,
  input  logic       qm1,
  input  logic       cnt_zero,
  output booth_ctl_t ctl,
  output logic       done
);

  booth_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          state_d  = ST_ARITH;
        end
      end
      ST_ARITH: begin
        ctl.sub = q0 & ~qm1;
        ctl.add = ~q0 & qm1;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        ctl.shift = 1'b1;
        ctl.dc    = ~cnt_zero;
        state_d   = cnt_zero ? ST_DONE : ST_ARITH;
      end
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  booth_ctl_t         ctl,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               q0,
  output logic               qm1,
  output logic               cnt_zero,
  output logic [2*WIDTH-1:0] product
);

  localparam int AW = WIDTH + 1;

  logic [WIDTH-1:0] m_q, m_d;
  logic [AW-1:0]    acc_q, acc_d;
  logic [WIDTH-1:0] q_q, q_d;
  logic             x_q, x_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    m_ext, sum;
  logic             reg_en, cnt_en;

  assign m_ext = {m_q[WIDTH-1], m_q};

  booth_addsub #(.W(AW)) u_addsub (
    .a   (acc_q),
    .b   (m_ext),
    .sub (ctl.sub),
    .y   (sum)
  );

  always_comb begin
    m_d   = m_q;
    acc_d = acc_q;
    q_d   = q_q;
    x_d   = x_q;
    cnt_d = cnt_q;
    if (ctl.load) begin
      m_d   = mcand;
      q_d   = mplier;
      acc_d = '0;
      x_d   = 1'b0;
      cnt_d = CNT_W'(WIDTH - 1);
    end
    if (ctl.add || ctl.sub) acc_d = sum;
    if (ctl.shift) begin
      acc_d = {acc_q[AW-1], acc_q[AW-1:1]};
      q_d   = {acc_q[0], q_q[WIDTH-1:1]};
      x_d   = q_q[0];
    end
    if (ctl.dc) cnt_d = cnt_q - 1'b1;
    reg_en = ctl.load | ctl.add | ctl.sub | ctl.shift;
    cnt_en = ctl.load | ctl.dc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q   <= '0;
      acc_q <= '0;
      q_q   <= '0;
      x_q   <= 1'b0;
    end else if (reg_en) begin
      m_q   <= m_d;
      acc_q <= acc_d;
      q_q   <= q_d;
      x_q   <= x_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign q0       = q_q[0];
  assign qm1      = x_q;
  assign cnt_zero = (cnt_q == '0);
  assign product  = {acc_q[WIDTH-1:0], q_q};

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;

  booth_ctl_t ctl;
  logic       q0, qm1, cnt_zero;
  logic       load_s, add_s, sub_s, shift_s, dc_s;

  booth_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .q0       (q0),
    .qm1      (qm1),
    .cnt_zero (cnt_zero),
    .ctl      (ctl),
    .done     (done)
  );

  booth_datapath #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .mcand    (mcand),
    .mplier   (mplier),
    .q0       (q0),
    .qm1      (qm1),
    .cnt_zero (cnt_zero),
    .product  (product)
  );

  assign load_s  = ctl.load;
  assign add_s   = ctl.add;
  assign sub_s   = ctl.sub;
  assign shift_s = ctl.shift;
  assign dc_s    = ctl.dc;

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
  parameter int WIDTH = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               load_s,
  input logic               add_s,
  input logic               sub_s,
  input logic               shift_s,
  input logic               dc_s,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  localparam int SCW = $clog2(WIDTH + 1) + 1;

  logic           busy_q, held_q;
  logic [SCW-1:0] steps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      held_q  <= 1'b0;
      steps_q <= '0;
    end else begin
      if (load_s)    busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      if (load_s)    held_q <= 1'b0;
      else if (done) held_q <= 1'b1;
      if (load_s)       steps_q <= '0;
      else if (shift_s) steps_q <= steps_q + 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                              // R5
  AST_STEP_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (steps_q == SCW'(WIDTH)));                           // R5
  AST_LOAD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    load_s |-> start);                                            // R2
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !load_s);                                          // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_s, add_s, sub_s, shift_s}));                   // R9
  AST_DC_WITH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    dc_s |-> shift_s);                                            // R9
  AST_SHIFT_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    shift_s |=> (product[WIDTH-1] == $past(product[WIDTH])));    // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !load_s) |=> $stable(product));                    // R8

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .load_s  (load_s),
  .add_s   (add_s),
  .sub_s   (sub_s),
  .shift_s (shift_s),
  .dc_s    (dc_s),
  .done    (done),
  .product (product)
);

// File: tb/test_booth_seq_mult.sv
module test_booth_seq_mult;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] mc = '0, mp = '0;
  logic        done;
  logic [31:0] prod;

  logic        start4 = 1'b0;
  logic [3:0]  mc4 = '0, mp4 = '0;
  logic        done4;
  logic [7:0]  prod4;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  booth_seq_mult #(.WIDTH(16)) i_booth_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mc), .mplier(mp),
    .done(done), .product(prod)
  );

  booth_seq_mult #(.WIDTH(4)) i_booth_seq_mult_w4 (
    .clk(clk), .rst_n(rst_n), .start(start4), .mcand(mc4), .mplier(mp4),
    .done(done4), .product(prod4)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Runs one 16-bit operation; optionally injects a start mid-operation.
  task automatic run16(input logic [15:0] a, input logic [15:0] b,
                       input bit inject);
    int          lat;
    int          e;
    logic [16:0] a17, sh;
    logic [31:0] mid, res;
    e   = int'($signed(a)) * int'($signed(b));
    a17 = b[0] ? (17'd0 - {a[15], a}) : 17'd0;
    sh  = {a17[16], a17[16:1]};
    mid = {sh[15:0], a17[0], b[15:1]};
    @(negedge clk);
    start = 1'b1; mc = a; mp = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(prod == {16'd0, b}, "R2 load view", 64'(prod), 64'({16'd0, b}));
    lat = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (inject && lat == 5) begin start = 1'b1; mc = ~a; mp = b + 16'd1; end
      if (inject && lat == 6) start = 1'b0;
      if (lat == 2)
        chk(prod == mid, "R3 R4 first step", 64'(prod), 64'(mid));
    end while (!done && lat < 100);
    res = prod;
    chk(lat == 32, inject ? "R7 R5 latency" : "R5 latency", 64'(lat), 64'd32);
    chk(res == 32'(e), inject ? "R7 R6 product" : "R3 R6 product",
        64'(res), 64'(32'(e)));
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R5 pulse width", 64'(done), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk(prod == res, "R8 hold", 64'(prod), 64'(res));
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b);
    int lat;
    int e;
    e = int'($signed(a)) * int'($signed(b));
    @(negedge clk);
    start4 = 1'b1; mc4 = a; mp4 = b;
    @(posedge clk);
    @(negedge clk);
    start4 = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end while (!done4 && lat < 40);
    chk(lat == 8, "R5 w4 latency", 64'(lat), 64'd8);
    chk(prod4 == 8'(e), "R6 w4 exhaustive", 64'(prod4), 64'(8'(e)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] corner [8];
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'hFFFF;
    corner[3] = 16'h7FFF; corner[4] = 16'h8000; corner[5] = 16'h0002;
    corner[6] = 16'h5555; corner[7] = 16'hAAAA;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
    chk(prod == 32'd0, "R1 reset product", 64'(prod), 64'd0);
    chk(prod4 == 8'd0, "R1 reset product w4", 64'(prod4), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prod == 32'd0 && !done, "R1 idle after release", 64'(prod), 64'd0);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run16(corner[i], corner[j], 1'b0);
    run16(16'h8000, 16'h8000, 1'b0);
    run16(16'h1234, 16'h8765, 1'b1);
    run16(16'h8000, 16'hFFFF, 1'b1);
    for (int k = 0; k < 300; k++)
      run16(16'($urandom), 16'($urandom), 1'b0);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run4(4'(a), 4'(b));
    summary();
  end

endmodule